// File: doc/BRIEF.md
# 16-bit ALU with Excess Register

This block is the arithmetic and logic unit of a small word-addressed processor. Each operation takes a 5-bit opcode, two 16-bit operands `b` and `a`, and the current value of the excess register (EX). It returns a new `b` value, a new EX value, a flag saying whether EX is to be written back, and a condition flag for the compare-and-skip opcodes. Signed values are two's complement. The EX word carries the carry, the borrow, the high half of a product, the fractional part of a quotient, or the bits pushed out by a shift. Each of these has its own encoding.

An operation is launched by a one-cycle `start_i` pulse while `busy_o` is low. All opcodes except the four division opcodes finish in one cycle. Division, signed and unsigned, runs one quotient bit per cycle through a shared restoring divider. Division by zero does not trap: it finishes at once with zero results. Results appear together with a one-cycle `done_o` pulse and are held on the outputs until the next result arrives.

Top module: `alu16_ex`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `ex_we_o` and `cond_o` are low, and `res_o` and `ex_o` are zero.
- R2: ADD (0x02) gives b+a with EX=0x0001 on unsigned carry, else 0. SUB (0x03) gives b-a with EX=0xFFFF on borrow, else 0. ADX (0x1A) gives b+a+EX with EX=0x0001 if the sum exceeds 0xFFFF, else 0. SBX (0x1B) gives b-a+EX with EX=0xFFFF if the true value is negative, 0x0001 if it exceeds 0xFFFF, else 0.
- R3: MUL (0x04) gives the low 16 bits of the unsigned product and puts the high 16 bits in EX. MLI (0x05) does the same with signed operands.
- R4: DIV (0x06) gives b/a unsigned with EX = ((b<<16)/a) & 0xFFFF. DVI (0x07) does the same signed, truncating toward zero for both words. 0x8000 DVI 0xFFFF gives 0x8000 with EX=0.
- R5: MOD (0x08) gives b%a unsigned. MDI (0x09) gives a signed remainder with the sign of the dividend (-7 MDI 16 = -7). Both output the incoming EX unchanged.
- R6: When a=0, the opcodes 0x06 to 0x09 give result 0. DIV and DVI also give EX=0. All four complete one cycle after start.
- R7: SHR (0x0D) gives the upper word of ({b,0x0000}>>a) as the result and the lower word as EX. ASR (0x0E) does the same with an arithmetic shift. SHL (0x0F) gives the low word of (b<<a) as the result and the high word as EX. For a of 16 or more, SHR and SHL give 0 and ASR gives all sign bits.
- R8: SET (0x01), STI (0x1E) and STD (0x1F) return a. AND (0x0A), BOR (0x0B) and XOR (0x0C) return the bitwise result. Unlisted opcodes return b. All of these output the incoming EX unchanged with `ex_we_o` low.
- R9: Opcodes 0x10 to 0x17 return b with `ex_we_o` low and set `cond_o` to the following tests, in opcode order: (b&a)!=0, (b&a)==0, b==a, b!=a, b>a unsigned, b>a signed, b<a unsigned, b<a signed.
- R10: `ex_we_o` is high for opcodes 0x02-0x07, 0x0D-0x0F, 0x1A and 0x1B, and low for all others. `ex_we_o` and `cond_o` are high only in a `done_o` cycle.
- R11: A non-division operation, or a division by zero, raises `done_o` in the cycle after the start edge. A division with nonzero a holds `busy_o` high for 2·W cycles and raises `done_o` in the cycle 2·W+1 after the start edge.
- R12: A `start_i` while `busy_o` is high is ignored. A `start_i` in the cycle where `done_o` is high is accepted.
- R13: `res_o` and `ex_o` change only at edges that raise `done_o`; otherwise they hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch an operation (ignored while busy) |
| op_i | input | 5 | Opcode |
| b_i | input | W | First operand (destination value) |
| a_i | input | W | Second operand |
| ex_i | input | W | Current excess register |
| busy_o | output | 1 | Divider iterating |
| done_o | output | 1 | One-cycle result-valid pulse |
| res_o | output | W | New b value |
| ex_o | output | W | New EX value |
| ex_we_o | output | 1 | EX should be written (valid with done) |
| cond_o | output | 1 | Compare result (valid with done) |

## Verification
Two events can fall in the same cycle: a finishing division and a new operation request. One case is a start issued while the divider still has iterations to run. The bench drives an ADD mid-division and checks three things: the finishing result is the quotient, the latency is still 2·W+1, and no extra done pulse follows. The other case is a start issued in the very cycle `done_o` presents a quotient. The bench checks that the quotient is visible in that cycle and that the new one-cycle result replaces it on the next edge.

// File: rtl/alu16_ex.sv
module alu16_ex #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [4:0]   op_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] ex_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] res_o,
  output logic [W-1:0] ex_o,
  output logic         ex_we_o,
  output logic         cond_o
);
  localparam int DW   = 2 * W;
  localparam int SW   = $clog2(DW) + 1;
  localparam int CW   = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);
  localparam logic [W-1:0]  ONE  = W'(1);

  localparam logic [4:0] OP_SET = 5'h01, OP_ADD = 5'h02, OP_SUB = 5'h03,
    OP_MUL = 5'h04, OP_MLI = 5'h05, OP_DIV = 5'h06, OP_DVI = 5'h07,
    OP_MOD = 5'h08, OP_MDI = 5'h09, OP_AND = 5'h0a, OP_BOR = 5'h0b,
    OP_XOR = 5'h0c, OP_SHR = 5'h0d, OP_ASR = 5'h0e, OP_SHL = 5'h0f,
    OP_ADX = 5'h1a, OP_SBX = 5'h1b, OP_STI = 5'h1e, OP_STD = 5'h1f;

  // one-cycle datapath
  logic [W:0]            add_s, sub_s;
  logic [W+1:0]          adx_s;
  logic signed [W+2:0]   sbx_d;
  logic [DW-1:0]         mul_u;
  logic signed [DW-1:0]  mul_s;
  logic [SW-1:0]         sh_amt;
  logic [DW-1:0]         shr_t, shl_t;
  logic signed [DW-1:0]  asr_t;
  logic [W-1:0]          c_res, c_ex;
  logic                  c_we, c_cond;

  assign add_s  = {1'b0, b_i} + {1'b0, a_i};
  assign sub_s  = {1'b0, b_i} - {1'b0, a_i};
  assign adx_s  = {2'b0, b_i} + {2'b0, a_i} + {2'b0, ex_i};
  assign sbx_d  = $signed({3'b0, b_i}) - $signed({3'b0, a_i}) + $signed({3'b0, ex_i});
  assign mul_u  = {{W{1'b0}}, b_i} * {{W{1'b0}}, a_i};
  assign mul_s  = $signed({{W{b_i[W-1]}}, b_i}) * $signed({{W{a_i[W-1]}}, a_i});
  assign sh_amt = ({{(32-W){1'b0}}, a_i} >= DW) ? SW'(DW) : a_i[SW-1:0];
  assign shr_t  = {b_i, {W{1'b0}}} >> sh_amt;
  assign asr_t  = $signed({b_i, {W{1'b0}}}) >>> sh_amt;
  assign shl_t  = {{W{1'b0}}, b_i} << sh_amt;

  always_comb begin
    c_res  = b_i;
    c_ex   = ex_i;
    c_we   = 1'b0;
    c_cond = 1'b0;
    case (op_i)
      OP_SET, OP_STI, OP_STD: c_res = a_i;
      OP_ADD: begin c_res = add_s[W-1:0]; c_ex = add_s[W] ? ONE : '0; c_we = 1'b1; end
      OP_SUB: begin c_res = sub_s[W-1:0]; c_ex = sub_s[W] ? '1 : '0;  c_we = 1'b1; end
      OP_MUL: begin c_res = mul_u[W-1:0]; c_ex = mul_u[DW-1:W]; c_we = 1'b1; end
      OP_MLI: begin c_res = mul_s[W-1:0]; c_ex = mul_s[DW-1:W]; c_we = 1'b1; end
      OP_DIV, OP_DVI: begin c_res = '0; c_ex = '0; c_we = 1'b1; end
      OP_MOD, OP_MDI: c_res = '0;
      OP_AND: c_res = b_i & a_i;
      OP_BOR: c_res = b_i | a_i;
      OP_XOR: c_res = b_i ^ a_i;
      OP_SHR: begin c_res = shr_t[DW-1:W]; c_ex = shr_t[W-1:0]; c_we = 1'b1; end
      OP_ASR: begin c_res = asr_t[DW-1:W]; c_ex = asr_t[W-1:0]; c_we = 1'b1; end
      OP_SHL: begin c_res = shl_t[W-1:0];  c_ex = shl_t[DW-1:W]; c_we = 1'b1; end
      OP_ADX: begin
        c_res = adx_s[W-1:0];
        c_ex  = (adx_s[W+1:W] != 2'b0) ? ONE : '0;
        c_we  = 1'b1;
      end
      OP_SBX: begin
        c_res = sbx_d[W-1:0];
        c_ex  = sbx_d[W+2] ? '1 : ((sbx_d[W+1:W] != 2'b0) ? ONE : '0);
        c_we  = 1'b1;
      end
      5'h10: c_cond = (b_i & a_i) != '0;
      5'h11: c_cond = (b_i & a_i) == '0;
      5'h12: c_cond = b_i == a_i;
      5'h13: c_cond = b_i != a_i;
      5'h14: c_cond = b_i > a_i;
      5'h15: c_cond = $signed(b_i) > $signed(a_i);
      5'h16: c_cond = b_i < a_i;
      5'h17: c_cond = $signed(b_i) < $signed(a_i);
      default: ;
    endcase
  end

  // iterative divider
  logic          is_div, sgn_op, frac_op;
  logic [W-1:0]  mag_b, mag_a;
  logic [DW-1:0] q, nq, qneg;
  logic [W-1:0]  r, nr, dvs, ex_keep;
  logic [CW-1:0] cnt;
  logic          d_frac, d_negq, d_negr;
  logic [W:0]    trial;
  logic          ge;
  logic [W-1:0]  f_res, f_ex;

  assign is_div  = (op_i == OP_DIV) || (op_i == OP_DVI) || (op_i == OP_MOD) || (op_i == OP_MDI);
  assign sgn_op  = (op_i == OP_DVI) || (op_i == OP_MDI);
  assign frac_op = (op_i == OP_DIV) || (op_i == OP_DVI);
  assign mag_b   = (sgn_op && b_i[W-1]) ? -b_i : b_i;
  assign mag_a   = (sgn_op && a_i[W-1]) ? -a_i : a_i;

  assign trial = {r, q[DW-1]};
  assign ge    = trial >= {1'b0, dvs};
  assign nr    = ge ? W'(trial - {1'b0, dvs}) : trial[W-1:0];
  assign nq    = {q[DW-2:0], ge};
  assign qneg  = -nq;

  assign f_res = d_frac ? (d_negq ? -nq[DW-1:W] : nq[DW-1:W]) : (d_negr ? -nr : nr);
  assign f_ex  = d_frac ? (d_negq ? qneg[W-1:0] : nq[W-1:0]) : ex_keep;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      res_o   <= '0;
      ex_o    <= '0;
      ex_we_o <= 1'b0;
      cond_o  <= 1'b0;
      q       <= '0;
      r       <= '0;
      dvs     <= '0;
      ex_keep <= '0;
      cnt     <= '0;
      d_frac  <= 1'b0;
      d_negq  <= 1'b0;
      d_negr  <= 1'b0;
    end else begin
      done_o  <= 1'b0;
      ex_we_o <= 1'b0;
      cond_o  <= 1'b0;
      if (busy_o) begin
        q   <= nq;
        r   <= nr;
        cnt <= cnt + 1'b1;
        if (cnt == LAST) begin
          busy_o  <= 1'b0;
          done_o  <= 1'b1;
          res_o   <= f_res;
          ex_o    <= f_ex;
          ex_we_o <= d_frac;
        end
      end else if (start_i) begin
        if (is_div && a_i != '0) begin
          busy_o  <= 1'b1;
          cnt     <= '0;
          r       <= '0;
          q       <= frac_op ? {mag_b, {W{1'b0}}} : {{W{1'b0}}, mag_b};
          dvs     <= mag_a;
          ex_keep <= ex_i;
          d_frac  <= frac_op;
          d_negq  <= sgn_op && (b_i[W-1] ^ a_i[W-1]);
          d_negr  <= sgn_op && b_i[W-1];
        end else begin
          done_o  <= 1'b1;
          res_o   <= c_res;
          ex_o    <= c_ex;
          ex_we_o <= c_we;
          cond_o  <= c_cond;
        end
      end
    end
  end
endmodule

// File: rtl/alu16_ex_chk.sv
module alu16_ex_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic [4:0]   op_i,
  input logic [W-1:0] a_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] res_o,
  input logic [W-1:0] ex_o,
  input logic         ex_we_o,
  input logic         cond_o
);
  logic div_req;
  assign div_req = (op_i >= 5'h06) && (op_i <= 5'h09);

  AST_FLAGS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> (!ex_we_o && !cond_o));  // R10

  AST_COND_NO_EXWE: assert property (@(posedge clk) disable iff (!rst_n)
    cond_o |-> !ex_we_o);  // R9

  AST_QUICK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && !div_req) |=> (done_o && !busy_o));  // R11

  AST_DIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && div_req && a_i == '0) |=> (done_o && res_o == '0));  // R6

  AST_DIV_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && div_req && a_i != '0) |=> (busy_o && !done_o));  // R11

  AST_NO_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !done_o);  // R12

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |=> (!done_o |-> ($stable(res_o) && $stable(ex_o))));  // R13
endmodule

bind alu16_ex alu16_ex_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .a_i(a_i),
  .busy_o(busy_o), .done_o(done_o), .res_o(res_o), .ex_o(ex_o),
  .ex_we_o(ex_we_o), .cond_o(cond_o)
);

// File: tb/alu16_ex_tb.sv
module alu16_ex_tb;
  localparam int W = 16;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [4:0]   op_i = '0;
  logic [W-1:0] b_i = '0, a_i = '0, ex_i = '0;
  logic         busy_o, done_o, ex_we_o, cond_o;
  logic [W-1:0] res_o, ex_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  alu16_ex #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .b_i(b_i),
    .a_i(a_i), .ex_i(ex_i), .busy_o(busy_o), .done_o(done_o), .res_o(res_o),
    .ex_o(ex_o), .ex_we_o(ex_we_o), .cond_o(cond_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [4:0] op, input logic [15:0] b, input logic [15:0] a,
                                input logic [15:0] ex, output logic [15:0] r, output logic [15:0] e,
                                output logic we, output logic c);
    longint sb, sa, t;
    logic [31:0] u;
    logic signed [31:0] s;
    sb = longint'($signed(b));
    sa = longint'($signed(a));
    r = b; e = ex; we = 1'b0; c = 1'b0;
    case (op)
      5'h01, 5'h1e, 5'h1f: r = a;
      5'h02: begin t = longint'(b) + longint'(a); r = t[15:0]; e = (t > 65535) ? 16'h1 : 16'h0; we = 1; end
      5'h03: begin t = longint'(b) - longint'(a); r = t[15:0]; e = (t < 0) ? 16'hffff : 16'h0; we = 1; end
      5'h04: begin t = longint'(b) * longint'(a); r = t[15:0]; e = t[31:16]; we = 1; end
      5'h05: begin t = sb * sa; r = t[15:0]; e = t[31:16]; we = 1; end
      5'h06: begin
        we = 1;
        if (a == 0) begin r = 0; e = 0; end
        else begin t = (longint'(b) * 65536) / longint'(a); r = 16'(longint'(b) / longint'(a)); e = t[15:0]; end
      end
      5'h07: begin
        we = 1;
        if (a == 0) begin r = 0; e = 0; end
        else begin t = (sb * 65536) / sa; r = 16'(sb / sa); e = t[15:0]; end
      end
      5'h08: r = (a == 0) ? 16'h0 : 16'(longint'(b) % longint'(a));
      5'h09: r = (a == 0) ? 16'h0 : 16'(sb % sa);
      5'h0a: r = b & a;
      5'h0b: r = b | a;
      5'h0c: r = b ^ a;
      5'h0d: begin u = {b, 16'h0} >> a; r = u[31:16]; e = u[15:0]; we = 1; end
      5'h0e: begin s = $signed({b, 16'h0}) >>> a; r = s[31:16]; e = s[15:0]; we = 1; end
      5'h0f: begin u = {16'h0, b} << a; r = u[15:0]; e = u[31:16]; we = 1; end
      5'h10: c = (b & a) != 0;
      5'h11: c = (b & a) == 0;
      5'h12: c = b == a;
      5'h13: c = b != a;
      5'h14: c = b > a;
      5'h15: c = sb > sa;
      5'h16: c = b < a;
      5'h17: c = sb < sa;
      5'h1a: begin t = longint'(b) + longint'(a) + longint'(ex); r = t[15:0]; e = (t > 65535) ? 16'h1 : 16'h0; we = 1; end
      5'h1b: begin
        t = longint'(b) - longint'(a) + longint'(ex); r = t[15:0];
        e = (t < 0) ? 16'hffff : ((t > 65535) ? 16'h1 : 16'h0); we = 1;
      end
      default: ;
    endcase
  endfunction

  task automatic run_op(input string tag, input logic [4:0] op, input logic [15:0] b,
                        input logic [15:0] a, input logic [15:0] ex);
    logic [15:0] er, ee;
    logic ew, ec;
    int cyc, lat;
    model(op, b, a, ex, er, ee, ew, ec);
    lat = ((op >= 5'h06) && (op <= 5'h09) && a != 0) ? 2 * W + 1 : 1;
    @(negedge clk);
    start_i = 1; op_i = op; b_i = b; a_i = a; ex_i = ex;
    @(negedge clk);
    start_i = 0;
    cyc = 1;
    while (!done_o && cyc < 100) begin @(negedge clk); cyc++; end
    chk(cyc == lat, {tag, " R11 latency"}, cyc, lat);
    chk(res_o == er, {tag, " result"}, res_o, er);
    chk(ex_o == ee, {tag, " ex"}, ex_o, ee);
    chk(ex_we_o == ew, {tag, " R10 ex_we"}, ex_we_o, ew);
    chk(cond_o == ec, {tag, " R9 cond"}, cond_o, ec);
  endtask

  task automatic t_reset;
    chk(!busy_o && !done_o && !ex_we_o && !cond_o, "R1 flags", {busy_o, done_o, ex_we_o, cond_o}, 0);
    chk(res_o == 0 && ex_o == 0, "R1 data", {res_o, ex_o}, 0);
  endtask

  task automatic t_arith;
    run_op("R2 add carry", 5'h02, 16'hffff, 16'h0002, 16'h1234);
    run_op("R2 add plain", 5'h02, 16'h1000, 16'h0234, 16'h0);
    run_op("R2 sub borrow", 5'h03, 16'h0001, 16'h0002, 16'h0);
    run_op("R2 sub plain", 5'h03, 16'h0005, 16'h0002, 16'h7);
    run_op("R2 adx carry", 5'h1a, 16'hfffe, 16'h0001, 16'h0001);
    run_op("R2 adx plain", 5'h1a, 16'h0010, 16'h0001, 16'h0003);
    run_op("R2 sbx under", 5'h1b, 16'h0001, 16'h0005, 16'h0002);
    run_op("R2 sbx over", 5'h1b, 16'hfff0, 16'h0001, 16'hffff);
  endtask

  task automatic t_mul;
    run_op("R3 mul", 16'h0 == 0 ? 5'h04 : 5'h04, 16'h1234, 16'h5678, 16'h0);
    run_op("R3 mul max", 5'h04, 16'hffff, 16'hffff, 16'h0);
    run_op("R3 mli neg", 5'h05, 16'hfffe, 16'h0003, 16'h0);
    run_op("R3 mli negneg", 5'h05, 16'h8000, 16'h8000, 16'h0);
  endtask

  task automatic t_div;
    run_op("R4 div", 5'h06, 16'h0007, 16'h0002, 16'h0);
    run_op("R4 div big", 16'h0 == 0 ? 5'h06 : 5'h06, 16'hfff3, 16'h0123, 16'h0);
    run_op("R4 dvi trunc", 5'h07, 16'hfff9, 16'h0002, 16'h0);
    run_op("R4 dvi neg div", 5'h07, 16'h0064, 16'hfff9, 16'h0);
    run_op("R4 dvi min by -1", 5'h07, 16'h8000, 16'hffff, 16'h0);
  endtask

  task automatic t_mod;
    run_op("R5 mod", 5'h08, 16'h0064, 16'h0007, 16'hbeef);
    run_op("R5 mdi -7 by 16", 5'h09, 16'hfff9, 16'h0010, 16'h1111);
    run_op("R5 mdi 7 by -3", 5'h09, 16'h0007, 16'hfffd, 16'h0);
  endtask

  task automatic t_divzero;
    run_op("R6 div zero", 5'h06, 16'h1234, 16'h0000, 16'h5555);
    run_op("R6 dvi zero", 5'h07, 16'h8000, 16'h0000, 16'h5555);
    run_op("R6 mod zero", 5'h08, 16'h1234, 16'h0000, 16'h5555);
    run_op("R6 mdi zero", 5'h09, 16'hfff9, 16'h0000, 16'h5555);
  endtask

  task automatic t_shift;
    run_op("R7 shr", 5'h0d, 16'h8421, 16'h0004, 16'h0);
    run_op("R7 asr", 5'h0e, 16'h8421, 16'h0004, 16'h0);
    run_op("R7 shl", 5'h0f, 16'h8421, 16'h0004, 16'h0);
    run_op("R7 shr 20", 5'h0d, 16'hf00f, 16'd20, 16'h0);
    run_op("R7 asr 40", 5'h0e, 16'h9000, 16'd40, 16'h0);
    run_op("R7 shl 17", 5'h0f, 16'h4001, 16'd17, 16'h0);
    run_op("R7 shl huge", 5'h0f, 16'hffff, 16'h1000, 16'h0);
  endtask

  task automatic t_logic;
    run_op("R8 set", 5'h01, 16'h1111, 16'habcd, 16'h7777);
    run_op("R8 and", 5'h0a, 16'hff00, 16'h0ff0, 16'h7777);
    run_op("R8 bor", 5'h0b, 16'hff00, 16'h0ff0, 16'h7777);
    run_op("R8 xor", 5'h0c, 16'hff00, 16'h0ff0, 16'h7777);
    run_op("R8 sti", 5'h1e, 16'h0001, 16'h2222, 16'h7777);
    run_op("R8 unused", 5'h18, 16'h3333, 16'h4444, 16'h7777);
  endtask

  task automatic t_cmp;
    for (int k = 0; k < 8; k++) begin
      run_op("R9 cmp a", 5'(16 + k), 16'h8001, 16'h0001, 16'h0);
      run_op("R9 cmp b", 5'(16 + k), 16'h0002, 16'hfff0, 16'h0);
      run_op("R9 cmp eq", 5'(16 + k), 16'h0f0f, 16'h0f0f, 16'h0);
    end
  endtask

  task automatic t_busy_ignore;
    int cyc;
    @(negedge clk);
    start_i = 1; op_i = 5'h06; b_i = 16'h0100; a_i = 16'h0003; ex_i = 0;
    @(negedge clk);
    start_i = 0; cyc = 1;
    repeat (4) begin @(negedge clk); cyc++; end
    chk(busy_o == 1, "R11 busy mid-division", busy_o, 1);
    start_i = 1; op_i = 5'h02; b_i = 16'h0001; a_i = 16'h0001;
    @(negedge clk); cyc++;
    start_i = 0;
    while (!done_o && cyc < 100) begin @(negedge clk); cyc++; end
    chk(cyc == 2 * W + 1, "R12 latency with ignored start", cyc, 2 * W + 1);
    chk(res_o == 16'h0055 && ex_o == 16'h5555, "R12 quotient kept", {res_o, ex_o}, 32'h00555555);
    @(negedge clk);
    chk(done_o == 0, "R12 no extra done", done_o, 0);
  endtask

  task automatic t_back2back;
    int cyc;
    @(negedge clk);
    start_i = 1; op_i = 5'h06; b_i = 16'h0009; a_i = 16'h0004; ex_i = 0;
    @(negedge clk);
    start_i = 0; cyc = 1;
    while (!done_o && cyc < 100) begin @(negedge clk); cyc++; end
    chk(res_o == 16'h0002 && ex_o == 16'h4000, "R12 quotient in done cycle", {res_o, ex_o}, 32'h00024000);
    start_i = 1; op_i = 5'h03; b_i = 16'h0000; a_i = 16'h0001; ex_i = 0;
    @(negedge clk);
    start_i = 0;
    chk(done_o == 1, "R12 start in done cycle accepted", done_o, 1);
    chk(res_o == 16'hffff && ex_o == 16'hffff, "R12 new result", {res_o, ex_o}, 32'hffffffff);
  endtask

  task automatic t_hold;
    logic [15:0] r0, e0;
    run_op("R13 seed", 5'h04, 16'h0300, 16'h0300, 16'h0);
    r0 = res_o; e0 = ex_o;
    @(negedge clk);
    b_i = 16'hdead; a_i = 16'hbeef; ex_i = 16'h1234; op_i = 5'h02;
    repeat (5) @(negedge clk);
    chk(done_o == 0 && res_o == r0 && ex_o == e0, "R13 hold", {res_o, ex_o}, {r0, e0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_arith();
    t_mul();
    t_div();
    t_mod();
    t_divzero();
    t_shift();
    t_logic();
    t_cmp();
    t_busy_ignore();
    t_back2back();
    t_hold();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule